// File: doc/BRIEF.md
# Two-Operand NaN Result Selector

This block decides the result word of a two-input single-precision operation when at least one of the two operands is a NaN. Each operand is sorted into one of three classes: ordinary value, quiet NaN or signaling NaN. An operand that is a signaling NaN raises the invalid flag. A two-bit policy input selects one of four propagation rules, and a further control picks the direction used by one of them. The chosen operand is returned as it is, or in a silenced form if it is signaling.

Silencing follows a polarity input. With standard polarity, a set top fraction bit marks a quiet NaN, and silencing sets that bit. With inverted polarity the meaning of that bit is reversed, and a chosen signaling NaN is replaced by the default NaN. A default-NaN mode forces the default NaN as the result and leaves the invalid flag unchanged. The arithmetic datapath is assumed to call this block only when one of its inputs is a NaN, and it muxes the result into its own output. The path is purely combinational.

Top module: `nanprop_sel`

## Requirements
- R1: An operand is a NaN when its exponent field [30:23] is all ones and its fraction [22:0] is nonzero. With `inv_pol`=0 a NaN is quiet when bit 22 is 1. With `inv_pol`=1 it is quiet when bit 22 is 0. `invalid` is 1 exactly when at least one operand is a signaling NaN.
- R2: With `dflt_mode`=1, `result` is the default NaN: 32'h7FC00000 for `inv_pol`=0 and 32'h7FBFFFFF for `inv_pol`=1. `invalid` still follows R1.
- R3: Policy 0 chooses a if a is signaling, else b if b is signaling, else a if a is quiet, else b.
- R4: Policy 1 chooses a if a is any NaN, else b.
- R5: Policy 2 with `use_first`=1 chooses a if a is a NaN, else b.
- R6: Policy 2 with `use_first`=0 chooses b if b is a NaN, else a.
- R7: Policy 3 handles NaN classes as follows. A signaling/quiet pair returns the quiet operand. A NaN paired with an ordinary value returns the NaN. Two NaNs of the same class go to the comparison of R8.
- R8: The policy 3 comparison uses bits [30:0] of each operand as an unsigned key, and the larger key wins. If the keys are equal, the operand with sign bit 0 wins. If both operands are identical, b is chosen.
- R9: With `inv_pol`=0 and `dflt_mode`=0, a chosen signaling NaN is returned with bit 22 set and every other bit kept. A chosen quiet NaN is returned unchanged.
- R10: With `inv_pol`=1 and `dflt_mode`=0, a chosen signaling NaN is replaced by 32'h7FBFFFFF. A chosen quiet NaN is returned unchanged.
- R11: `use_first` has no effect on `result` or `invalid` under policies 0, 1 and 3.
- R12: `result` and `invalid` follow the inputs with no clock and no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand, single-precision bit pattern |
| op_b | input | 32 | Second operand, single-precision bit pattern |
| inv_pol | input | 1 | 0: bit 22 set means quiet; 1: bit 22 set means signaling |
| dflt_mode | input | 1 | Force the default NaN as result |
| policy | input | 2 | 0 signaling-first, 1 operand-order, 2 selectable, 3 significand |
| use_first | input | 1 | Direction for policy 2: 1 prefers a, 0 prefers b |
| result | output | 32 | Propagated NaN |
| invalid | output | 1 | Invalid-operation flag |

## Verification
The assertions that check the chosen class, that the result is a NaN, and that the result is quiet all assume that at least one operand is a NaN. Each of them is guarded by that condition, so a pair of ordinary values checks nothing. The bench keeps to the same contract: its sweep skips the ordinary/ordinary pairing, and every directed case uses at least one NaN operand. Because the block has no state, every input combination is an independent vector. Each vector is applied one cycle after the previous one and sampled on the falling clock edge.

// File: rtl/nanprop_pkg.sv
package nanprop_pkg;

  // Operand class as seen by the selection rules
  typedef enum logic [1:0] {
    NC_NUM    = 2'd0,
    NC_QUIET  = 2'd1,
    NC_SIGNAL = 2'd2
  } nan_cls_e;

  // Propagation rule selected by the policy input
  typedef enum logic [1:0] {
    POL_SIG_FIRST = 2'd0,
    POL_ORDER     = 2'd1,
    POL_SELECT    = 2'd2,
    POL_MAG       = 2'd3
  } pick_pol_e;

  function automatic logic cls_is_nan(input nan_cls_e c);
    return (c == NC_QUIET) || (c == NC_SIGNAL);
  endfunction

endpackage

// File: rtl/nanprop_classify.sv
module nanprop_classify
  import nanprop_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] op,
  input  logic                  inv_pol,
  output nan_cls_e              cls
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic exp_ones, frac_nz, top_bit, is_nan, is_quiet;

  assign exp_f    = op[WORD_W-2 -: EXP_W];
  assign frac_f   = op[FRAC_W-1:0];
  assign exp_ones = &exp_f;
  assign frac_nz  = |frac_f;
  assign top_bit  = frac_f[FRAC_W-1];
  assign is_nan   = exp_ones & frac_nz;
  assign is_quiet = inv_pol ? ~top_bit : top_bit;

  always_comb begin
    if (!is_nan)       cls = NC_NUM;
    else if (is_quiet) cls = NC_QUIET;
    else               cls = NC_SIGNAL;
  end

  // A signaling class under inverted polarity needs the top bit set
  always_comb begin
    if (cls == NC_SIGNAL && inv_pol)
      assert_inv_signal_top_R1: assert (op[FRAC_W-1] == 1'b1);
    if (cls != NC_NUM)
      assert_nan_field_R1: assert (&op[WORD_W-2 -: EXP_W]);
  end

endmodule

// File: rtl/nanprop_mag_cmp.sv
module nanprop_mag_cmp #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic              a_larger
);
  localparam int KEY_W = WORD_W - 1;

  // Magnitude key: the word with the sign bit shifted out
  function automatic logic [KEY_W-1:0] mag_key(input logic [WORD_W-1:0] v);
    return v[KEY_W-1:0];
  endfunction

  logic [KEY_W-1:0] key_a, key_b;
  logic key_gt, key_lt, sign_tie_a;

  assign key_a      = mag_key(op_a);
  assign key_b      = mag_key(op_b);
  assign key_gt     = key_a > key_b;
  assign key_lt     = key_a < key_b;
  assign sign_tie_a = ~op_a[WORD_W-1] & op_b[WORD_W-1];
  assign a_larger   = key_gt | (~key_lt & sign_tie_a);

  always_comb begin
    if (op_a == op_b)
      assert_identical_prefers_b_R8: assert (!a_larger);
  end

endmodule

// File: rtl/nanprop_pick.sv
module nanprop_pick
  import nanprop_pkg::*;
(
  input  nan_cls_e    a_cls,
  input  nan_cls_e    b_cls,
  input  logic [1:0]  policy,
  input  logic        use_first,
  input  logic        a_larger,
  output logic        pick_b
);
  pick_pol_e pol;
  logic a_nan, b_nan, a_sig, b_sig;
  logic pick_sigfirst, pick_order, pick_select, pick_mag;
  nan_cls_e chosen_cls;

  assign pol   = pick_pol_e'(policy);
  assign a_nan = cls_is_nan(a_cls);
  assign b_nan = cls_is_nan(b_cls);
  assign a_sig = (a_cls == NC_SIGNAL);
  assign b_sig = (b_cls == NC_SIGNAL);

  // Each rule returns 1 to take operand b
  assign pick_sigfirst = a_sig ? 1'b0 : b_sig ? 1'b1 : a_nan ? 1'b0 : 1'b1;
  assign pick_order    = ~a_nan;
  assign pick_select   = use_first ? ~a_nan : b_nan;

  always_comb begin
    if (!a_nan)                pick_mag = 1'b1;
    else if (!b_nan)           pick_mag = 1'b0;
    else if (a_cls != b_cls)   pick_mag = (b_cls == NC_QUIET);
    else                       pick_mag = ~a_larger;
  end

  always_comb begin
    unique case (pol)
      POL_SIG_FIRST: pick_b = pick_sigfirst;
      POL_ORDER:     pick_b = pick_order;
      POL_SELECT:    pick_b = pick_select;
      default:       pick_b = pick_mag;
    endcase
  end

  assign chosen_cls = pick_b ? b_cls : a_cls;

  always_comb begin
    if (a_nan || b_nan) begin
      assert_chosen_is_nan_R7: assert (chosen_cls != NC_NUM);
      if (pol == POL_SIG_FIRST && (a_sig || b_sig))
        assert_sigfirst_takes_signal_R3: assert (chosen_cls == NC_SIGNAL);
      if (pol == POL_ORDER && a_nan)
        assert_order_takes_a_R4: assert (!pick_b);
      if (pol == POL_MAG && (a_sig != b_sig) && a_nan && b_nan)
        assert_mag_quiet_wins_R7: assert (chosen_cls == NC_QUIET);
    end
  end

endmodule

// File: rtl/nanprop_quieten.sv
module nanprop_quieten
  import nanprop_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] chosen,
  input  nan_cls_e              chosen_cls,
  input  logic                  inv_pol,
  input  logic                  dflt_mode,
  output logic [EXP_W+FRAC_W:0] result
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;

  // Default NaN: positive, exponent all ones, fraction per polarity
  function automatic logic [WORD_W-1:0] dflt_nan(input logic inv);
    logic [WORD_W-1:0] v;
    v = '0;
    v[WORD_W-2 -: EXP_W] = '1;
    if (inv) v[FRAC_W-2:0] = '1;
    else     v[FRAC_W-1]   = 1'b1;
    return v;
  endfunction

  function automatic logic [WORD_W-1:0] set_quiet(input logic [WORD_W-1:0] v);
    logic [WORD_W-1:0] r;
    r = v;
    r[FRAC_W-1] = 1'b1;
    return r;
  endfunction

  logic need_silence;
  assign need_silence = (chosen_cls == NC_SIGNAL);

  always_comb begin
    if (dflt_mode)         result = dflt_nan(inv_pol);
    else if (!need_silence) result = chosen;
    else if (inv_pol)      result = dflt_nan(1'b1);
    else                   result = set_quiet(chosen);
  end

  always_comb begin
    if (chosen_cls != NC_NUM) begin
      assert_result_nan_exp_R9: assert (&result[WORD_W-2 -: EXP_W]);
      assert_result_nan_frac_R10: assert (|result[FRAC_W-1:0]);
      if (!inv_pol)
        assert_std_result_quiet_R9: assert (result[FRAC_W-1]);
      else
        assert_inv_result_quiet_R10: assert (!result[FRAC_W-1]);
    end
  end

endmodule

// File: rtl/nanprop_sel.sv
module nanprop_sel
  import nanprop_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  input  logic        inv_pol,
  input  logic        dflt_mode,
  input  logic [1:0]  policy,
  input  logic        use_first,
  output logic [31:0] result,
  output logic        invalid
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;

  nan_cls_e a_cls, b_cls, chosen_cls;
  logic a_larger, pick_b;
  logic [WORD_W-1:0] chosen;

  nanprop_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (
    .op(op_a), .inv_pol(inv_pol), .cls(a_cls)
  );

  nanprop_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (
    .op(op_b), .inv_pol(inv_pol), .cls(b_cls)
  );

  nanprop_mag_cmp #(.WORD_W(WORD_W)) u_mag (
    .op_a(op_a), .op_b(op_b), .a_larger(a_larger)
  );

  nanprop_pick u_pick (
    .a_cls(a_cls), .b_cls(b_cls), .policy(policy), .use_first(use_first),
    .a_larger(a_larger), .pick_b(pick_b)
  );

  assign chosen     = pick_b ? op_b : op_a;
  assign chosen_cls = pick_b ? b_cls : a_cls;

  nanprop_quieten #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_quiet (
    .chosen(chosen), .chosen_cls(chosen_cls), .inv_pol(inv_pol),
    .dflt_mode(dflt_mode), .result(result)
  );

  assign invalid = (a_cls == NC_SIGNAL) || (b_cls == NC_SIGNAL);

  always_comb begin
    if (cls_is_nan(a_cls) || cls_is_nan(b_cls)) begin
      if (!dflt_mode && !invalid)
        assert_quiet_passthrough_R10: assert (result == op_a || result == op_b);
      if (!dflt_mode && !inv_pol)
        assert_std_keeps_low_bits_R9: assert (result[FRAC_W-2:0] == op_a[FRAC_W-2:0]
                                              || result[FRAC_W-2:0] == op_b[FRAC_W-2:0]);
      if (dflt_mode)
        assert_dflt_sign_clear_R2: assert (!result[WORD_W-1]);
    end
  end

endmodule

// File: tb/nanprop_sel_tb.sv
module nanprop_sel_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  int          cycles = 0;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  logic [31:0] op_a = 32'h7FC00011;
  logic [31:0] op_b = 32'h3F800000;
  logic        inv_pol = 1'b0;
  logic        dflt_mode = 1'b0;
  logic [1:0]  policy = 2'd0;
  logic        use_first = 1'b0;
  wire  [31:0] result;
  wire         invalid;

  nanprop_sel u_dut (
    .op_a(op_a), .op_b(op_b), .inv_pol(inv_pol), .dflt_mode(dflt_mode),
    .policy(policy), .use_first(use_first), .result(result), .invalid(invalid)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  // ---------------- reference model from the requirements -------------
  // class: 0 ordinary, 1 quiet, 2 signaling
  function automatic int ref_cls(input logic [31:0] v, input logic inv);
    if (v[30:23] != 8'hFF || v[22:0] == 23'd0) return 0;
    if ((v[22] == 1'b1) != (inv == 1'b1)) return 1;
    return 2;
  endfunction

  function automatic logic [31:0] ref_dnan(input logic inv);
    return inv ? 32'h7FBFFFFF : 32'h7FC00000;
  endfunction

  function automatic bit ref_take_b(input logic [31:0] a, input logic [31:0] b,
                                    input logic inv, input logic [1:0] pol,
                                    input logic uf);
    int ca, cb;
    ca = ref_cls(a, inv);
    cb = ref_cls(b, inv);
    case (pol)
      2'd0: begin
        if (ca == 2) return 0;
        if (cb == 2) return 1;
        return (ca == 1) ? 0 : 1;
      end
      2'd1: return (ca == 0);
      2'd2: return uf ? (ca == 0) : (cb != 0);
      default: begin
        if (ca == 0) return 1;
        if (cb == 0) return 0;
        if (ca != cb) return (cb == 1);
        if (a[30:0] > b[30:0]) return 0;
        if (a[30:0] < b[30:0]) return 1;
        if (a[31] == 1'b0 && b[31] == 1'b1) return 0;
        return 1;
      end
    endcase
  endfunction

  function automatic logic [31:0] ref_result(input logic [31:0] a, input logic [31:0] b,
                                             input logic inv, input logic dm,
                                             input logic [1:0] pol, input logic uf);
    logic [31:0] c;
    if (dm) return ref_dnan(inv);
    c = ref_take_b(a, b, inv, pol, uf) ? b : a;
    if (ref_cls(c, inv) != 2) return c;
    if (inv) return ref_dnan(1'b1);
    return c | 32'h00400000;
  endfunction

  function automatic logic ref_invalid(input logic [31:0] a, input logic [31:0] b,
                                       input logic inv);
    return (ref_cls(a, inv) == 2) || (ref_cls(b, inv) == 2);
  endfunction

  // Sample operands: same patterns flip meaning under inverted polarity
  function automatic logic [31:0] sample(input int c, input logic inv, input bit side_b);
    bit top;
    if (c == 0) return side_b ? 32'hC0490FDB : 32'h3F800000;
    top = (c == 1) ? !inv : inv;
    if (side_b) return top ? 32'hFFC00022 : 32'hFF800022;
    return top ? 32'h7FC00011 : 32'h7F800011;
  endfunction

  // ---------------- drive and check ------------------------------------
  task automatic apply_check(input string tag, input logic [31:0] a, input logic [31:0] b,
                             input logic ip, input logic dm, input logic [1:0] pol,
                             input logic uf, input logic [31:0] er, input logic ei);
    @(posedge clk);
    #1;
    op_a = a; op_b = b; inv_pol = ip; dflt_mode = dm; policy = pol; use_first = uf;
    @(negedge clk);
    n_checks++;
    if (result !== er || invalid !== ei) begin
      n_fail++;
      $display("FAIL %s: a=%h b=%h pol=%0d uf=%b inv=%b dm=%b result=%h invalid=%b expected result=%h invalid=%b",
               tag, a, b, pol, uf, ip, dm, result, invalid, er, ei);
    end
  endtask

  task automatic t_reset_state();
    // R12: the combinational path settles from the reset-time inputs
    @(negedge clk);
    n_checks++;
    if (result !== 32'h7FC00011 || invalid !== 1'b0) begin
      n_fail++;
      $display("FAIL R12: result=%h invalid=%b expected result=7fc00011 invalid=0",
               result, invalid);
    end
  endtask

  task automatic t_sweep();
    for (int ip = 0; ip < 2; ip++)
      for (int dm = 0; dm < 2; dm++)
        for (int pol = 0; pol < 4; pol++)
          for (int uf = 0; uf < 2; uf++)
            for (int ca = 0; ca < 3; ca++)
              for (int cb = 0; cb < 3; cb++) begin
                string tag;
                logic [31:0] a, b;
                if (ca == 0 && cb == 0) continue;
                a = sample(ca, ip[0], 1'b0);
                b = sample(cb, ip[0], 1'b1);
                if (dm != 0)                  tag = "R2";
                else if (pol == 0)            tag = "R3";
                else if (pol == 1)            tag = "R4";
                else if (pol == 2 && uf != 0) tag = "R5";
                else if (pol == 2)            tag = "R6";
                else                          tag = "R7";
                apply_check(tag, a, b, ip[0], dm[0], pol[1:0], uf[0],
                            ref_result(a, b, ip[0], dm[0], pol[1:0], uf[0]),
                            ref_invalid(a, b, ip[0]));
              end
  endtask

  task automatic t_invalid_flag();
    // R1: signaling a, ordinary b; quiet pair gives no flag
    apply_check("R1", 32'h7F800001, 32'h00000000, 1'b0, 1'b0, 2'd1, 1'b0, 32'h7FC00001, 1'b1);
    apply_check("R1", 32'h7FC00001, 32'hFFC00002, 1'b0, 1'b0, 2'd1, 1'b0, 32'h7FC00001, 1'b0);
    apply_check("R1", 32'h7FC00001, 32'h7F800000, 1'b1, 1'b0, 2'd1, 1'b0, 32'h7FBFFFFF, 1'b1);
  endtask

  task automatic t_mag_rules();
    // R8: larger key wins; sign decides equal keys
    apply_check("R8", 32'h7F800009, 32'h7F800005, 1'b0, 1'b0, 2'd3, 1'b0, 32'h7FC00009, 1'b1);
    apply_check("R8", 32'h7F800005, 32'h7F800009, 1'b0, 1'b0, 2'd3, 1'b0, 32'h7FC00009, 1'b1);
    apply_check("R8", 32'hFFC00001, 32'h7FC00001, 1'b0, 1'b0, 2'd3, 1'b0, 32'h7FC00001, 1'b0);
    apply_check("R8", 32'h7FC00001, 32'hFFC00001, 1'b0, 1'b0, 2'd3, 1'b0, 32'h7FC00001, 1'b0);
    apply_check("R8", 32'hFFC00003, 32'h7FC00001, 1'b0, 1'b0, 2'd3, 1'b0, 32'hFFC00003, 1'b0);
  endtask

  task automatic t_silence();
    // R9: sign and low bits kept, bit 22 set
    apply_check("R9", 32'hFF80ABCD, 32'h3F800000, 1'b0, 1'b0, 2'd0, 1'b0, 32'hFFC0ABCD, 1'b1);
    // R10: inverted polarity replaces a chosen signaling NaN, passes a quiet one
    apply_check("R10", 32'hFFC0ABCD, 32'h3F800000, 1'b1, 1'b0, 2'd0, 1'b0, 32'h7FBFFFFF, 1'b1);
    apply_check("R10", 32'hFF80ABCD, 32'h3F800000, 1'b1, 1'b0, 2'd0, 1'b0, 32'hFF80ABCD, 1'b0);
  endtask

  task automatic t_use_first_ignored();
    // R11: same operands, use_first toggled under policies 0, 1 and 3
    for (int pol = 0; pol < 4; pol++) begin
      if (pol == 2) continue;
      for (int uf = 0; uf < 2; uf++)
        apply_check("R11", 32'h3F800000, 32'hFFC00022, 1'b0, 1'b0, pol[1:0], uf[0],
                    32'hFFC00022, 1'b0);
    end
  endtask

  initial begin
    t_reset_state();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_sweep();
    t_invalid_flag();
    t_mag_rules();
    t_silence();
    t_use_first_ignored();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule